// File: doc/BRIEF.md
# Serial-to-byte framer with boundary search

The block sits behind a serial receiver in a SONET/SDH line interface. It takes one data bit per cycle of the serial bit clock and shifts it into a 16-bit history. It delivers whole bytes together with a byte clock that runs at one eighth of the bit rate. All eight bit rotations of the history are watched at the same time for the start-of-frame marker, which is three A1 bytes followed by three A2 bytes. The rotation that is used for the byte bus is held in a register. That register changes only during a boundary search.

A search starts on a low-to-high transition of the out-of-frame request. It ends at the first byte time in which some rotation completes the marker. That rotation becomes the new boundary, and the in-frame status returns high. From then on the boundary stays fixed until the next request edge. Marker detection on the chosen rotation runs at all times, so the sync pulse keeps marking every frame start whatever the request level. A disable input holds the boundary frozen. A divided reference clock, at the bit rate over 3 or over 12, is also provided for the downstream clock logic.

Top module: `sonet_framer`

## Requirements
- R1: `byte_clk_o` has a period of 8 bit clocks, high for 4 and low for 4, and it is high in reset.
- R2: `data_o` changes only on the bit-clock edge where `byte_clk_o` falls. Bits are taken most significant first, so the earliest received bit of a byte appears on bit 7.
- R3: `sync_o` goes high for exactly 8 bit clocks when three bytes of 0xF6 followed by three bytes of 0x28 are seen at the current rotation. It is high while the third 0x28 is on `data_o`, and this holds at any level of `oof_i`.
- R4: A search starts only on a rising edge of `oof_i`. A steady high level does nothing. `in_frame_o` is low from that edge until the search locks.
- R5: During a search all 8 rotations are tested at every byte time, and the first one to complete the marker is taken (the lowest rotation wins a tie). At that byte `sync_o` pulses and `in_frame_o` goes high, and the bytes that follow are correctly aligned.
- R6: While locked, a marker that appears only at another rotation changes neither the boundary nor `sync_o`.
- R7: While `rec_dis_i` is high, rising edges of `oof_i` start no search and the boundary cannot change.
- R8: With `rate_hi_i`=0, `ref_clk_o` has a period of 3 bit clocks and is high for 1. With `rate_hi_i`=1, it has a period of 12 and is high for 6.
- R9: Reset clears `data_o`, `sync_o` and `ref_clk_o` to 0, sets `in_frame_o` to 1 and sets the rotation to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial data, one bit per clock |
| oof_i | input | 1 | Out-of-frame request; a rising edge starts a search |
| rec_dis_i | input | 1 | Blocks the start of a search and any boundary change |
| rate_hi_i | input | 1 | Selects the reference divider: 0 gives /3, 1 gives /12 |
| byte_clk_o | output | 1 | Byte clock, bit clock divided by 8 |
| data_o | output | 8 | Aligned byte |
| sync_o | output | 1 | Frame marker pulse, one byte period long |
| in_frame_o | output | 1 | Low while a search is pending |
| ref_clk_o | output | 1 | Divided reference clock |

## Verification
The marker is sent at three bit offsets, each a different rotation. A search must lock at each offset, and the bytes that follow must come out as the known payload, which shows that the chosen rotation is correct. The same marker is then sent with OOF held high and no new edge. At the locked alignment it must give a sync pulse. After a shift of a few bits it must give nothing, which separates a frozen boundary from one that keeps re-searching. The disable case sends a shifted marker just after a fresh OOF edge and expects neither lock nor a drop in in-frame status. The reference divider is measured for both period and high time at each rate.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  parameter int unsigned BYTE_W = 8;
  parameter logic [BYTE_W-1:0] MARK_A1 = 8'hF6;
  parameter logic [BYTE_W-1:0] MARK_A2 = 8'h28;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sfr_byte_clk.sv
module sfr_byte_clk #(
  parameter int unsigned W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o,
  output logic byte_clk_o
);
  localparam int unsigned PW = $clog2(W);
  localparam logic [PW-1:0] HALF = PW'(W / 2);
  localparam logic [PW-1:0] LAST = PW'(W - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  // the strobe edge moves phase into the low half, i.e. the falling byte edge
  assign strobe_o   = (phase_q == HALF - 1'b1);
  assign byte_clk_o = (phase_q < HALF);
endmodule

// File: rtl/sfr_mark_det.sv
module sfr_mark_det
  import sfr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] A1 = MARK_A1,
  parameter logic [BYTE_W-1:0] A2 = MARK_A2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  strobe_i,
  input  byte_t byte_i,
  output logic  hit_o
);
  logic [2:0] st_q, st_d;
  logic is1, is2;

  assign is1 = (byte_i == A1);
  assign is2 = (byte_i == A2);

  always_comb begin
    unique case (st_q)
      3'd0, 3'd1, 3'd2: st_d = is1 ? 3'(st_q + 3'd1) : 3'd0;
      3'd3:             st_d = is2 ? 3'd4 : (is1 ? 3'd3 : 3'd0); // long A1 runs allowed
      3'd4:             st_d = is2 ? 3'd5 : (is1 ? 3'd1 : 3'd0);
      default:          st_d = is1 ? 3'd1 : 3'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       st_q <= '0;
    else if (strobe_i) st_q <= st_d;
  end

  assign hit_o = strobe_i && (st_q == 3'd5) && is2;
endmodule

// File: rtl/sfr_low_pick.sv
module sfr_low_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]         req_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) idx_o = ($clog2(N))'(i);
  end
  assign any_o = |req_i;
endmodule

// File: rtl/sfr_ref_div.sv
module sfr_ref_div #(
  parameter int unsigned DIV_LO = 3,
  parameter int unsigned DIV_HI = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_hi_i,
  output logic ref_clk_o
);
  localparam int unsigned CW = $clog2(DIV_HI + 1);
  localparam logic [CW-1:0] LIM_LO = CW'(DIV_LO);
  localparam logic [CW-1:0] LIM_HI = CW'(DIV_HI);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  assign lim   = rate_hi_i ? LIM_HI : LIM_LO;
  assign cnt_d = (cnt_q >= lim - 1'b1) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      ref_clk_o <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      ref_clk_o <= (cnt_d < (lim >> 1));
    end
  end
endmodule

// File: rtl/sonet_framer.sv
module sonet_framer
  import sfr_pkg::*;
#(
  parameter int unsigned DIV_LO = 3,
  parameter int unsigned DIV_HI = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              oof_i,
  input  logic              rec_dis_i,
  input  logic              rate_hi_i,
  output logic              byte_clk_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              sync_o,
  output logic              in_frame_o,
  output logic              ref_clk_o
);
  localparam int unsigned NROT = BYTE_W;
  localparam int unsigned RW   = $clog2(NROT);
  localparam int unsigned HW   = 2 * BYTE_W;

  logic          strobe;
  logic [HW-1:0] hist_q;
  byte_t         win [NROT];
  logic [NROT-1:0] hit;
  logic          any_hit;
  logic [RW-1:0] pick, rot_q;
  logic          oof_q, searching_q, oof_rise;

  sfr_byte_clk #(.W(BYTE_W)) u_bclk (
    .clk_i, .rst_ni, .strobe_o(strobe), .byte_clk_o
  );

  // newest bit enters at bit 0; higher index is older
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[HW-2:0], ser_i};
  end

  for (genvar r = 0; r < NROT; r++) begin : g_rot
    assign win[r] = hist_q[r +: BYTE_W];
    sfr_mark_det u_det (
      .clk_i, .rst_ni, .strobe_i(strobe), .byte_i(win[r]), .hit_o(hit[r])
    );
  end

  sfr_low_pick #(.N(NROT)) u_pick (.req_i(hit), .any_o(any_hit), .idx_o(pick));

  assign oof_rise = oof_i && !oof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oof_q       <= 1'b0;
      searching_q <= 1'b0;
      in_frame_o  <= 1'b1;
      rot_q       <= '0;
      data_o      <= '0;
      sync_o      <= 1'b0;
    end else begin
      oof_q <= oof_i;
      if (strobe) begin
        data_o <= win[rot_q];
        sync_o <= hit[rot_q];
        if (searching_q && !rec_dis_i && any_hit) begin
          rot_q       <= pick;
          data_o      <= win[pick];
          sync_o      <= 1'b1;
          searching_q <= 1'b0;
          in_frame_o  <= 1'b1;
        end
      end
      // a fresh request overrides a lock in the same cycle
      if (oof_rise && !rec_dis_i) begin
        searching_q <= 1'b1;
        in_frame_o  <= 1'b0;
      end
    end
  end

  sfr_ref_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_ref (
    .clk_i, .rst_ni, .rate_hi_i, .ref_clk_o
  );
endmodule

// File: rtl/sonet_framer_chk.sv
module sonet_framer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         oof_i,
  input logic         rec_dis_i,
  input logic         byte_clk_o,
  input logic [W-1:0] data_o,
  input logic         sync_o,
  input logic         in_frame_o
);
  logic [7:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= byte_clk_o ? 8'd0 : lo_cnt + 8'd1;
      hi_cnt <= byte_clk_o ? hi_cnt + 8'd1 : 8'd0;
    end
  end

  p_byte_lo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_clk_o) |-> lo_cnt == 8'(W / 2));
  p_byte_hi_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(byte_clk_o) |-> hi_cnt == 8'(W / 2));
  p_data_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> $fell(byte_clk_o));
  p_sync_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sync_o) |-> $fell(byte_clk_o));
  p_search_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_frame_o) |-> $past(oof_i));
  p_disable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_frame_o) |-> !$past(rec_dis_i));
  p_lock_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_frame_o) |-> sync_o);
endmodule

bind sonet_framer sonet_framer_chk #(.W(sfr_pkg::BYTE_W)) u_chk (
  .clk_i, .rst_ni, .oof_i, .rec_dis_i, .byte_clk_o, .data_o, .sync_o, .in_frame_o
);

// File: tb/sonet_framer_tb_top.sv
module sonet_framer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b0, oof = 1'b0, rec_dis = 1'b0, rate_hi = 1'b0;
  logic byte_clk, sync, in_frame, ref_clk;
  logic [7:0] data;

  int vectors = 0, miscompares = 0;
  int cyc = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  sonet_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .oof_i(oof), .rec_dis_i(rec_dis),
    .rate_hi_i(rate_hi), .byte_clk_o(byte_clk), .data_o(data), .sync_o(sync),
    .in_frame_o(in_frame), .ref_clk_o(ref_clk)
  );

  // byte log, filled at each falling byte clock
  logic [7:0] log_d [256];
  logic       log_s [256];
  int log_n = 0;
  logic bc_prev = 1'b1;
  int sw = 0, last_sw = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (bc_prev && !byte_clk && log_n < 256) begin
      log_d[log_n] = data;
      log_s[log_n] = sync;
      log_n = log_n + 1;
    end
    bc_prev = byte_clk;
    if (sync) sw = sw + 1;
    else if (sw != 0) begin last_sw = sw; sw = 0; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser = b;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic send_frame();
    for (int i = 0; i < 4; i++) send_byte(8'h00);
    for (int i = 0; i < 3; i++) send_byte(8'hF6);
    for (int i = 0; i < 3; i++) send_byte(8'h28);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    for (int i = 0; i < 3; i++) send_byte(8'h00);
  endtask

  function automatic int count_sync();
    int n = 0;
    for (int i = 0; i < log_n; i++) if (log_s[i]) n++;
    return n;
  endfunction

  // one sync expected; byte at sync is A2 and payload follows aligned
  task automatic expect_locked(input string tag);
    int at = -1;
    logic [7:0] pay [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    for (int i = log_n - 1; i >= 0; i--) if (log_s[i]) at = i;
    check(count_sync() == 1, {tag, " R3 sync count"}, count_sync(), 1);
    if (at >= 0 && at + 4 < log_n) begin
      check(log_d[at] == 8'h28, {tag, " R3 byte at sync"}, log_d[at], 8'h28);
      for (int k = 0; k < 4; k++)
        check(log_d[at+1+k] == pay[k], {tag, " R5 aligned payload"}, log_d[at+1+k], pay[k]);
    end else check(1'b0, {tag, " R5 sync position"}, at, 0);
    check(last_sw == 8, {tag, " R3 sync width"}, last_sw, 8);
    check(in_frame == 1'b1, {tag, " R5 in_frame after lock"}, in_frame, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(data == 8'h00 && sync == 1'b0, "R9 reset data/sync", {data, sync}, 0);
    check(in_frame == 1'b1, "R9 reset in_frame", in_frame, 1);
    check(ref_clk == 1'b0 && byte_clk == 1'b1, "R9 reset clocks", {ref_clk, byte_clk}, 1);
  endtask

  task automatic t_byte_clk();
    int hi = 0, per = 0;
    while (byte_clk) @(negedge clk);
    while (!byte_clk) @(negedge clk);
    while (byte_clk) begin hi++; per++; @(negedge clk); end
    while (!byte_clk) begin per++; @(negedge clk); end
    check(hi == 4, "R1 byte clock high time", hi, 4);
    check(per == 8, "R1 byte clock period", per, 8);
  endtask

  task automatic t_search(input int extra, input string tag);
    for (int i = 0; i < extra; i++) send_bit(1'b0);
    oof = 1'b0;
    send_byte(8'h00);
    oof = 1'b1;
    log_n = 0;
    send_byte(8'h00);
    check(in_frame == 1'b0, {tag, " R4 in_frame low during search"}, in_frame, 0);
    send_frame();
    expect_locked(tag);
  endtask

  task automatic t_hold();
    // oof stays high: marker at locked rotation still syncs, no new search
    log_n = 0;
    send_frame();
    expect_locked("hold R3 R4");
    // shifted marker must be ignored while locked
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    log_n = 0;
    send_frame();
    check(count_sync() == 0, "R6 shifted marker ignored", count_sync(), 0);
    check(in_frame == 1'b1, "R6 in_frame held", in_frame, 1);
  endtask

  task automatic t_disable();
    rec_dis = 1'b1;
    oof = 1'b0;
    send_byte(8'h00);
    oof = 1'b1;
    send_bit(1'b0); send_bit(1'b0);
    check(in_frame == 1'b1, "R7 edge ignored", in_frame, 1);
    log_n = 0;
    send_frame();
    check(count_sync() == 0, "R7 no relock", count_sync(), 0);
    check(in_frame == 1'b1, "R7 in_frame stays", in_frame, 1);
    rec_dis = 1'b0;
    log_n = 0;
    send_frame();
    check(count_sync() == 0, "R4 steady high no search", count_sync(), 0);
  endtask

  task automatic t_ref(input logic hi_sel, input int exp_per, input int exp_hi);
    int hi = 0, per = 0;
    rate_hi = hi_sel;
    repeat (30) @(negedge clk);
    while (ref_clk) @(negedge clk);
    while (!ref_clk) @(negedge clk);
    while (ref_clk) begin hi++; per++; @(negedge clk); end
    while (!ref_clk) begin per++; @(negedge clk); end
    check(per == exp_per, "R8 ref clock period", per, exp_per);
    check(hi == exp_hi, "R8 ref clock high time", hi, exp_hi);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(data == 8'h00 && sync == 1'b0 && in_frame == 1'b1, "R9 mid-run reset",
          {data, sync, in_frame}, 1);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_byte_clk();
    t_search(3, "offset3");
    t_hold();
    t_search(6, "offset6");
    t_disable();
    t_search(1, "offset1");
    t_ref(1'b0, 3, 1);
    t_ref(1'b1, 12, 6);
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    wait (done || cyc > 150000);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule